// File: doc/BRIEF.md
# Lifting Step Processing Element

This block performs one lifting step of a wavelet transform on a stream of even/odd sample pairs. In predict mode it changes the odd lane and leaves the even lane as it is. In update mode it changes the even lane and leaves the odd lane as it is. The lane that changes is called the reference. The other lane feeds a tapped history line. The new reference value is `ref + (C1·x[j-p]) >>> R + (C2·x[j-q]) >>> R`, where `j` counts accepted pairs, `p` and `q` are tap offsets into the history, and `R` is the number of fractional bits of the constants. A future offset `f` delays both lanes by `f` pairs. With it, taps where `p < f` or `q < f` reach samples that arrive after the reference. A normalization mode scales the even lane by C1 (K) and the odd lane by C2 (1/K). A bypass mode passes the pair through unchanged.

The block has one multiplier and one adder. Each is used twice per pair. The multiplier forms C1·x[j-p] in the first cycle and C2·x[j-q] in the second. For that reason the input takes at most one pair every two cycles. The input is a valid/ready port. `in_ready` is high on every other cycle, and a pair transfers when `in_valid` and `in_ready` are both high. A source that is not accepted keeps `in_valid` and its data stable until it is. The output has no back-pressure. Each accepted pair gives exactly one `out_valid` pulse after a fixed latency, so the consumer must be able to take one pair every two cycles. The configuration inputs are static while a stream is in flight. They may change only while reset is held or when the pipeline is empty.

Top module: `lsp_lifting_pe`

## Requirements
- R1: `in_ready` is high on alternate cycles and never on two cycles in a row, so no more than one pair is accepted in any two cycles. A pair presented while `in_ready` is low is held and is accepted in the next ready cycle.
- R2: When `cfg_mode` = 1 (predict), for accepted pair j the outputs are `out_odd = odd[j-f] + (C1·even[j-p]) >>> R + (C2·even[j-q]) >>> R` and `out_even = even[j-f]`.
- R3: When `cfg_mode` = 2 (update), for accepted pair j the outputs are `out_even = even[j-f] + (C1·odd[j-p]) >>> R + (C2·odd[j-q]) >>> R` and `out_odd = odd[j-f]`.
- R4: Data and constants are signed two's complement. Each product is shifted right arithmetically by R (FRAC) bits, which rounds toward minus infinity. The sum is then truncated to its low DW bits, so it wraps on overflow.
- R5: The tap offsets p and q (0 to TAP_DEPTH-1) pick the history sample from that many pairs before the newest accepted one. Every sample from before the first pair after reset reads as zero.
- R6: The future offset f (0 to FUT_MAX) delays the reference and the pass-through lane by f pairs in both predict and update modes.
- R7: Outside normalization mode, the result of a pair accepted at clock edge E is driven with `out_valid` high after edge E+3. That is four cycles from the cycle in which the pair is presented. There is exactly one single-cycle pulse per accepted pair.
- R8: When `cfg_mode` = 3 (normalize), `out_even = (C1·even) >>> R` and `out_odd = (C2·odd) >>> R`, both truncated to DW bits. Both lanes appear together with `out_valid` after edge E+2, and p, q and f have no effect.
- R9: When `cfg_mode` = 0 (bypass), the pair comes out unchanged with the same timing as R7. The constants, p, q and f have no effect.
- R10: While `rst_n` is low, `out_valid`, `out_even` and `out_odd` are 0 and the history is cleared.
- R11: `out_even` and `out_odd` keep their last values on every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 0 bypass, 1 predict, 2 update, 3 normalize |
| cfg_c1 | input | CW | First constant (K in normalize mode), signed, R fractional bits |
| cfg_c2 | input | CW | Second constant (1/K in normalize mode), signed, R fractional bits |
| cfg_tap_p | input | log2(TAP_DEPTH) | Offset of the first tap |
| cfg_tap_q | input | log2(TAP_DEPTH) | Offset of the second tap |
| cfg_fut | input | log2(FUT_MAX+1) | Future offset in pairs |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input slot open this cycle |
| in_even | input | DW | Even sample, signed |
| in_odd | input | DW | Odd sample, signed |
| out_valid | output | 1 | Output pair valid, one cycle |
| out_even | output | DW | Even result |
| out_odd | output | DW | Odd result |

## Verification
Outputs are scored pair by pair against a model that keeps its own zero-filled copy of each lane's history. A tap, future-offset or lane-routing error therefore shows up as a wrong value on the first pair whose selected history sample is non-zero, which is often the second or third pair after reset. A wrong multiplier or adder phase mixes C1 and C2 terms or adds a term twice. That fails on the very first pair of any stream where C1 and C2 differ. A fault in the valid chain or the phase counter shows as an `out_valid` pulse on the wrong cycle, a missing pulse or an extra pulse. Each pulse is checked against the exact expected cycle.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    LSP_BYPASS  = 2'd0,
    LSP_PREDICT = 2'd1,
    LSP_UPDATE  = 2'd2,
    LSP_NORM    = 2'd3
  } lsp_mode_e;

endpackage

// File: rtl/lsp_tap_line.sv
// Shift register of lane samples; entry 0 is the newest accepted sample.
module lsp_tap_line #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(taps)); // R5

endmodule

// File: rtl/lsp_mac.sv
// One multiplier and one adder, each time-shared by the sequencer in the top.
module lsp_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 8,
  localparam int PW  = DW + CW,
  localparam int SW  = PW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [CW-1:0]  mul_c,
  input  logic signed [DW-1:0]  mul_x,
  input  logic signed [SW-1:0]  add_base,
  output logic signed [PW-1:0]  prod_now,
  output logic signed [PW-1:0]  prod_q,
  output logic signed [SW-1:0]  sum
);

  logic signed [PW-1:0] c_ext;
  logic signed [PW-1:0] x_ext;
  logic signed [PW-1:0] scaled;

  assign c_ext    = PW'(mul_c);
  assign x_ext    = PW'(mul_x);
  assign prod_now = c_ext * x_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_now;
  end

  assign scaled = prod_q >>> FRAC;
  assign sum    = add_base + SW'(scaled);

endmodule

// File: rtl/lsp_lifting_pe.sv
module lsp_lifting_pe
  import lsp_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int FRAC      = 8,
  parameter int TAP_DEPTH = 8,
  parameter int FUT_MAX   = 3,
  localparam int TAPW     = (TAP_DEPTH > 1) ? $clog2(TAP_DEPTH) : 1,
  localparam int FW       = (FUT_MAX > 0) ? $clog2(FUT_MAX + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic [CW-1:0]   cfg_c1,
  input  logic [CW-1:0]   cfg_c2,
  input  logic [TAPW-1:0] cfg_tap_p,
  input  logic [TAPW-1:0] cfg_tap_q,
  input  logic [FW-1:0]   cfg_fut,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_even,
  input  logic [DW-1:0]   in_odd,
  output logic            out_valid,
  output logic [DW-1:0]   out_even,
  output logic [DW-1:0]   out_odd
);

  localparam int REF_DEPTH = FUT_MAX + 1;
  localparam int X_DEPTH   = (TAP_DEPTH > REF_DEPTH) ? TAP_DEPTH : REF_DEPTH;
  localparam int PW        = DW + CW;
  localparam int SW        = PW + 2;

  lsp_mode_e mode;
  logic is_norm, is_byp, is_pred;
  assign mode    = lsp_mode_e'(cfg_mode);
  assign is_norm = (mode == LSP_NORM);
  assign is_byp  = (mode == LSP_BYPASS);
  assign is_pred = (mode == LSP_PREDICT);

  // Slot phase: a pair may enter only on every other cycle.
  logic ph;
  logic fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end
  assign in_ready = ~ph;
  assign fire     = in_valid & in_ready;

  // Lane routing: reference lane and history lane.
  logic [DW-1:0] ref_in, x_in;
  assign ref_in = is_pred ? in_odd  : in_even;
  assign x_in   = is_pred ? in_even : in_odd;

  logic [REF_DEPTH-1:0][DW-1:0] ref_taps;
  logic [X_DEPTH-1:0][DW-1:0]   x_taps;

  lsp_tap_line #(.W(DW), .DEPTH(REF_DEPTH)) u_ref_line (
    .clk(clk), .rst_n(rst_n), .shift(fire), .din(ref_in), .taps(ref_taps)
  );

  lsp_tap_line #(.W(DW), .DEPTH(X_DEPTH)) u_x_line (
    .clk(clk), .rst_n(rst_n), .shift(fire), .din(x_in), .taps(x_taps)
  );

  // Effective selects: normalization forces taps to zero; bypass/normalize ignore f.
  logic [TAPW-1:0] p_eff, q_eff;
  logic [FW-1:0]   f_lim, f_eff;
  assign p_eff = is_norm ? '0 : cfg_tap_p;
  assign q_eff = is_norm ? '0 : cfg_tap_q;
  assign f_lim = (cfg_fut > FW'(FUT_MAX)) ? FW'(FUT_MAX) : cfg_fut;
  assign f_eff = (is_norm | is_byp) ? '0 : f_lim;

  // Valid chain: v0 = first multiply cycle, v1 = second multiply / first add, v2 = second add.
  logic v0, v1, v2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0;
    end else begin
      v0 <= fire; v1 <= v0; v2 <= v1;
    end
  end

  // Shared multiplier / adder operand selection.
  logic signed [CW-1:0] mul_c;
  logic signed [DW-1:0] mul_x;
  logic signed [SW-1:0] add_base;
  logic signed [SW-1:0] acc;
  logic signed [PW-1:0] prod_now, prod_q;
  logic signed [SW-1:0] sum;

  assign mul_c    = v0 ? $signed(cfg_c1) : $signed(cfg_c2);
  assign mul_x    = v0 ? $signed(is_norm ? ref_taps[0] : x_taps[p_eff])
                       : $signed(x_taps[q_eff]);
  assign add_base = v1 ? SW'($signed(ref_taps[f_eff])) : acc;

  lsp_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .mul_c(mul_c), .mul_x(mul_x), .add_base(add_base),
    .prod_now(prod_now), .prod_q(prod_q), .sum(sum)
  );

  logic [DW-1:0] pass_r, byp_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_r <= '0; byp_r <= '0; acc <= '0;
    end else begin
      if (v0) begin
        pass_r <= x_taps[f_eff];
        byp_r  <= ref_taps[0];
      end
      if (v1) acc <= sum;
    end
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      out_valid <= is_norm ? v1 : v2;
      if (is_norm && v1) begin
        out_even <= DW'(prod_q >>> FRAC);
        out_odd  <= DW'(prod_now >>> FRAC);
      end else if (!is_norm && v2) begin
        case (mode)
          LSP_PREDICT: begin out_even <= pass_r; out_odd <= sum[DW-1:0]; end
          LSP_UPDATE:  begin out_even <= sum[DW-1:0]; out_odd <= pass_r; end
          default:     begin out_even <= byp_r; out_odd <= pass_r; end
        endcase
      end
    end
  end

  AST_READY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R1

  AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7

  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_norm && $past(fire, 4)) |-> out_valid); // R7

  AST_NORM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_norm && $past(fire, 3)) |-> out_valid); // R8

  AST_BYPASS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (is_byp && out_valid) |-> (out_even == $past(in_even, 4) && out_odd == $past(in_odd, 4))); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_even) && $stable(out_odd))); // R11

endmodule

// File: tb/tb_lsp_lifting_pe.sv
`timescale 1ns/1ps
module tb_lsp_lifting_pe;

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int R  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]    cfg_mode = '0;
  logic [CW-1:0] cfg_c1 = '0, cfg_c2 = '0;
  logic [2:0]    cfg_tap_p = '0, cfg_tap_q = '0;
  logic [1:0]    cfg_fut = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_even = '0, in_odd = '0;
  logic          out_valid;
  logic [DW-1:0] out_even, out_odd;

  lsp_lifting_pe dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_c1(cfg_c1), .cfg_c2(cfg_c2),
    .cfg_tap_p(cfg_tap_p), .cfg_tap_q(cfg_tap_q), .cfg_fut(cfg_fut),
    .in_valid(in_valid), .in_ready(in_ready), .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_even(out_even), .out_odd(out_odd)
  );

  always #2 clk = ~clk;  // 250 MHz

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R10";
  int m_mode, m_c1, m_c2, m_p, m_q, m_f;

  int     q_e[$];
  int     q_o[$];
  longint q_c[$];
  int     ev_h[$];
  int     od_h[$];

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  function automatic int tr(longint v);
    logic [DW-1:0] b;
    b = v[DW-1:0];
    return int'($signed(b));
  endfunction

  function automatic longint sh(longint v);
    return v >>> R;
  endfunction

  function automatic int hist(bit odd_lane, int k);
    if (k < 0) return 0;
    return odd_lane ? od_h[k] : ev_h[k];
  endfunction

  // Driver: presents one pair, holds it until accepted, pushes the expected result.
  task automatic send(int e, int o);
    int j, xe, xo;
    longint res;
    in_valid = 1'b1;
    in_even  = DW'(e);
    in_odd   = DW'(o);
    while (!in_ready) @(negedge clk);
    ev_h.push_back(e);
    od_h.push_back(o);
    j = ev_h.size() - 1;
    case (m_mode)
      1: begin // R2 predict
        res = longint'(hist(1, j - m_f)) + sh(longint'(m_c1) * hist(0, j - m_p))
              + sh(longint'(m_c2) * hist(0, j - m_q));
        xo = tr(res);
        xe = hist(0, j - m_f);
      end
      2: begin // R3 update
        res = longint'(hist(0, j - m_f)) + sh(longint'(m_c1) * hist(1, j - m_p))
              + sh(longint'(m_c2) * hist(1, j - m_q));
        xe = tr(res);
        xo = hist(1, j - m_f);
      end
      3: begin // R8 normalize
        xe = tr(sh(longint'(m_c1) * e));
        xo = tr(sh(longint'(m_c2) * o));
      end
      default: begin xe = e; xo = o; end // R9 bypass
    endcase
    q_e.push_back(xe);
    q_o.push_back(xo);
    q_c.push_back(cyc + 1 + ((m_mode == 3) ? 2 : 3));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each output pulse with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_e.size() == 0) begin
        check((m_mode == 3) ? "R8" : "R7", 1'b0, "unexpected out_valid", 1, 0);
      end else begin
        int xe, xo;
        longint xc;
        xe = q_e.pop_front();
        xo = q_o.pop_front();
        xc = q_c.pop_front();
        check(cur_req, int'($signed(out_even)) == xe, "out_even", int'($signed(out_even)), xe);
        check(cur_req, int'($signed(out_odd)) == xo, "out_odd", int'($signed(out_odd)), xo);
        check((m_mode == 3) ? "R8" : "R7", cyc == xc, "result cycle", cyc, xc);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    q_e.delete(); q_o.delete(); q_c.delete();
    ev_h.delete(); od_h.delete();
    // R10: reset state at the ports
    check("R10", out_valid == 1'b0, "out_valid in reset", out_valid, 0);
    check("R10", out_even == '0 && out_odd == '0, "outputs in reset", out_even | out_odd, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int pat_e(int pat, int i);
    case (pat)
      0: return 100 * i + 7;
      1: return (i % 2 == 0) ? 32767 : -32768;
      default: return -300 + 37 * i;
    endcase
  endfunction

  function automatic int pat_o(int pat, int i);
    case (pat)
      0: return 3 - 50 * i;
      1: return (i % 3 == 0) ? -32768 : 32767;
      default: return 1000 - 91 * i;
    endcase
  endfunction

  task automatic run(string req, int mode, int c1, int c2, int p, int q, int f, int pat, int n);
    logic [DW-1:0] he, ho;
    m_mode = mode; m_c1 = c1; m_c2 = c2; m_p = p; m_q = q; m_f = f;
    cfg_mode = 2'(mode); cfg_c1 = CW'(c1); cfg_c2 = CW'(c2);
    cfg_tap_p = 3'(p); cfg_tap_q = 3'(q); cfg_fut = 2'(f);
    cur_req = req;
    do_reset();
    for (int i = 0; i < n; i++) begin
      send(pat_e(pat, i), pat_o(pat, i));
      if (i % 5 == 4) repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    check("R7", q_e.size() == 0, "results outstanding", q_e.size(), 0);
    // R11: outputs hold while out_valid is low
    he = out_even; ho = out_odd;
    repeat (5) @(negedge clk);
    check("R11", out_even == he && out_odd == ho, "held outputs",
          {out_even, out_odd}, {he, ho});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    m_mode = 0; m_c1 = 0; m_c2 = 0; m_p = 0; m_q = 0; m_f = 0;
    do_reset();
    // R1: in_ready alternates cycle by cycle
    begin
      logic prev;
      prev = in_ready;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check("R1", in_ready != prev, "in_ready alternation", in_ready, !prev);
        prev = in_ready;
      end
    end
    // R9: bypass, constants/taps/future offset set but ignored
    run("R9", 0, 1234, -999, 3, 5, 2, 0, 10);
    // R2, R5: predict with adjacent taps
    run("R2/R5", 1, -128, 64, 0, 1, 0, 0, 12);
    // R3, R6: update with a future sample
    run("R3/R6", 2, 77, -200, 0, 2, 1, 2, 12);
    // R6, R5: predict, deepest taps and largest future offset
    run("R6/R5", 1, 300, -45, 7, 1, 3, 2, 14);
    // R4: extreme data and constants, shift rounding and wrap
    run("R4", 1, 32767, -32768, 0, 1, 0, 1, 12);
    run("R4", 2, -32768, 32767, 1, 1, 2, 1, 10);
    // R8: normalize, taps and future offset set but ignored
    run("R8", 3, 362, 181, 4, 6, 3, 0, 10);
    run("R8", 3, -700, 32767, 2, 7, 1, 1, 8);
    // R1: back-to-back pairs in bypass still land every two cycles
    run("R1", 0, 0, 0, 0, 0, 0, 2, 6);
    summary();
    $finish;
  end

endmodule